// File: doc/BRIEF.md
# Packet Register File

This block is a small bank of data registers that is reached only through framed packets on two valid/accept streams. A request packet enters on the input stream and begins with a header word. The low four bits of the header select the operation, and the bits just above them pick the register. A read request is a single beat that carries both the start and the stop flag. A write request is a header beat with start set and stop clear, followed by one payload beat that carries stop. The payload word is written into the addressed register.

Every legal request draws a response packet on the output stream. The response opens with a start beat that echoes the saved header word. For a read, the next beat holds the register contents. The response then closes with a stop beat whose data is zero. A header with an unknown opcode or the wrong framing is taken and dropped, and the block keeps waiting for the next header. A single control state machine runs the request, the register update and the response in turn, so only one request is in flight at any time.

Top module: `pkt_regfile`

## Requirements
- R1: While the active-low synchronous reset is low, in_accept and out_valid are 0. Reset clears every register to zero, so a later read of any register returns 0.
- R2: After reset is released, or after a response has finished, the block spends one cycle with in_accept low. It then holds in_accept high while it waits for a header.
- R3: A header is a beat with in_valid and in_start high while in_accept is high. A header with in_stop high and opcode 4'h1 in bits [3:0] is a read. After it is taken, in_accept drops and a response follows.
- R4: A header with in_stop low and opcode 4'h2 in bits [3:0] is a write. After it, the block takes payload beats. The first payload beat with in_stop high is written to the register whose index is header bits [4+AW-1:4]. Payload beats with in_stop low are taken and discarded.
- R5: The first response beat has out_start high and out_stop low. Its out_data equals the whole saved header word, so bits [3:0] echo the opcode. out_start is low on the cycle after that beat is accepted.
- R6: A read response has exactly three beats, and the middle beat carries the addressed register value with both flags low. A write response has exactly two beats.
- R7: The last response beat has out_stop high, out_start low and out_data zero. out_start and out_stop are never high together. out_valid is high only while a response is being sent.
- R8: While out_valid is high and out_accept is low, out_data, out_start and out_stop hold their values into the next cycle.
- R9: A header with any other opcode, a write opcode with in_stop high, or a read opcode with in_stop low is taken and dropped. No response follows, and in_accept stays high. A beat without in_start is ignored while the block waits for a header.
- R10: On the cycle after the stop beat is accepted, out_valid and in_accept are both low.
- R11: in_accept is low throughout the response, so input beats offered during that time are not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request beat present |
| in_start | input | 1 | Request beat is a header |
| in_stop | input | 1 | Request beat closes the packet |
| in_data | input | DW | Request word |
| in_accept | output | 1 | Block takes the offered request beat |
| out_valid | output | 1 | Response beat present |
| out_start | output | 1 | Response beat opens the packet |
| out_stop | output | 1 | Response beat closes the packet |
| out_data | output | DW | Response word |
| out_accept | input | 1 | Receiver takes the response beat |

## Verification
The bench applies random backpressure on every response. It checks that held beats do not change, since a design that moved its state or its data mux before acceptance would change a held beat or skip one. A design that decoded only the opcode would answer badly framed headers, such as a write with stop or a read without stop, with a spurious response. A design that ignored the stop flag on the payload would store a discarded payload beat. While a response is in progress the bench offers fresh request headers, to catch a design that raises in_accept too early. A mid-run reset followed by reads shows whether stale register contents survive.

// File: rtl/prf_pkg.sv
package prf_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_RD = 4'h1;
  localparam logic [OPC_W-1:0] OPC_WR = 4'h2;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_RDGAP = 3'd2,
    ST_PAY   = 3'd3,
    ST_SOP   = 3'd4,
    ST_MID   = 3'd5,
    ST_EOP   = 3'd6
  } prf_state_e;

  typedef enum logic [1:0] {SEL_ZERO, SEL_HDR, SEL_RD} prf_sel_e;

  function automatic logic opc_is_rd(input logic [OPC_W-1:0] op);
    return op == OPC_RD;
  endfunction

  function automatic logic opc_is_wr(input logic [OPC_W-1:0] op);
    return op == OPC_WR;
  endfunction

  // read request: single beat carrying both framing flags
  function automatic logic hdr_is_read(input logic sop, input logic eop,
                                       input logic [OPC_W-1:0] op);
    return sop && eop && opc_is_rd(op);
  endfunction

  // write request: header opens the packet, payload beat closes it
  function automatic logic hdr_is_write(input logic sop, input logic eop,
                                        input logic [OPC_W-1:0] op);
    return sop && !eop && opc_is_wr(op);
  endfunction
endpackage

// File: rtl/prf_hdr.sv
module prf_hdr #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] hdr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    hdr_q <= '0;
    else if (take) hdr_q <= din;
  end

  p_hdr_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> hdr_q == $past(din));
  p_hdr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(hdr_q));
endmodule

// File: rtl/prf_regs.sv
module prf_regs #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                          q[g] <= '0;
      else if (wr_en && wr_addr == AW'(g)) q[g] <= wr_data;
    end
  end

  assign rd_data = q[rd_addr];

  p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/prf_ctrl.sv
module prf_ctrl
  import prf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_start,
  input  logic             in_stop,
  input  logic [OPC_W-1:0] in_op,
  output logic             in_accept,
  input  logic [OPC_W-1:0] hdr_op,
  input  logic             out_accept,
  output logic             out_valid,
  output logic             out_start,
  output logic             out_stop,
  output prf_sel_e         out_sel,
  output logic             hdr_take,
  output logic             wr_en,
  output prf_state_e       state
);
  prf_state_e st, nxt;
  logic go_read, go_write, hdr_drop, resp_fire;

  // named events, shared by the next-state logic and the assertions
  assign hdr_take  = (st == ST_HDR) && in_valid && in_start;
  assign go_read   = hdr_take && hdr_is_read(in_start, in_stop, in_op);
  assign go_write  = hdr_take && hdr_is_write(in_start, in_stop, in_op);
  assign hdr_drop  = hdr_take && !go_read && !go_write;
  assign wr_en     = (st == ST_PAY) && in_valid && in_stop;
  assign resp_fire = out_valid && out_accept;

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE:  nxt = ST_HDR;
      ST_HDR:   if (go_read) nxt = ST_RDGAP;
                else if (go_write) nxt = ST_PAY;
      ST_RDGAP: nxt = ST_SOP;
      ST_PAY:   if (wr_en) nxt = ST_SOP;
      ST_SOP:   if (resp_fire) nxt = opc_is_rd(hdr_op) ? ST_MID : ST_EOP;
      ST_MID:   if (resp_fire) nxt = ST_EOP;
      ST_EOP:   if (resp_fire) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  always_comb begin
    in_accept = (st == ST_HDR) || (st == ST_PAY);
    out_valid = (st == ST_SOP) || (st == ST_MID) || (st == ST_EOP);
    out_start = (st == ST_SOP);
    out_stop  = (st == ST_EOP);
    unique case (st)
      ST_SOP:  out_sel = SEL_HDR;
      ST_MID:  out_sel = SEL_RD;
      default: out_sel = SEL_ZERO;
    endcase
  end

  assign state = st;

  p_idle_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |=> st == ST_HDR);
  p_read_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    go_read |=> st == ST_RDGAP);
  p_write_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    go_write |=> st == ST_PAY);
  p_drop_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_drop |=> st == ST_HDR && in_accept);
  p_no_accept_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_accept);
endmodule

// File: rtl/pkt_regfile.sv
module pkt_regfile
  import prf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NREG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_start,
  input  logic          in_stop,
  input  logic [DW-1:0] in_data,
  output logic          in_accept,
  output logic          out_valid,
  output logic          out_start,
  output logic          out_stop,
  output logic [DW-1:0] out_data,
  input  logic          out_accept
);
  localparam int AW = $clog2(NREG);

  logic [DW-1:0] hdr_q, rd_data;
  logic          hdr_take, wr_en;
  prf_sel_e      out_sel;
  prf_state_e    state;
  logic [AW-1:0] reg_idx;

  assign reg_idx = hdr_q[OPC_W +: AW];

  prf_ctrl u_ctrl (
    .clk, .rst_n, .in_valid, .in_start, .in_stop,
    .in_op(in_data[OPC_W-1:0]), .in_accept,
    .hdr_op(hdr_q[OPC_W-1:0]), .out_accept,
    .out_valid, .out_start, .out_stop, .out_sel,
    .hdr_take, .wr_en, .state
  );

  prf_hdr #(.DW(DW)) u_hdr (
    .clk, .rst_n, .take(hdr_take), .din(in_data), .hdr_q
  );

  prf_regs #(.DW(DW), .NREG(NREG)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr(reg_idx), .wr_data(in_data),
    .rd_addr(reg_idx), .rd_data
  );

  always_comb begin
    unique case (out_sel)
      SEL_HDR: out_data = hdr_q;
      SEL_RD:  out_data = rd_data;
      default: out_data = '0;
    endcase
  end

  p_start_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_start && out_stop));
  p_valid_in_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> state inside {ST_SOP, ST_MID, ST_EOP});
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_accept |=>
      $stable(out_data) && $stable(out_start) && $stable(out_stop));
  p_sop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_start && out_accept |=> !out_start);
  p_eop_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_stop && out_accept |=> !out_valid && !in_accept);
  p_sop_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_data[OPC_W-1:0] == hdr_q[OPC_W-1:0]);
endmodule

// File: tb/sim_pkt_regfile.sv
`timescale 1ns/1ps
module sim_pkt_regfile;
  localparam int DW   = 16;
  localparam int NREG = 8;
  localparam int AW   = 3;
  localparam int HW   = DW - 4 - AW;
  localparam logic [3:0] RD = 4'h1, WR = 4'h2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, in_valid, in_start, in_stop, in_accept;
  logic          out_valid, out_start, out_stop, out_accept;
  logic [DW-1:0] in_data, out_data;
  logic [DW-1:0] model [NREG];
  int total = 0, bad = 0;

  pkt_regfile #(.DW(DW), .NREG(NREG)) u0 (
    .clk, .rst_n, .in_valid, .in_start, .in_stop, .in_data, .in_accept,
    .out_valid, .out_start, .out_stop, .out_data, .out_accept
  );

  task automatic chk(input bit ok, input string req,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk_hdr(input logic [3:0] op,
      input logic [AW-1:0] a, input logic [HW-1:0] hi);
    return {hi, a, op};
  endfunction

  task automatic in_beat(input logic [DW-1:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_start = s; in_stop = e;
    while (!in_accept) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0;
  endtask

  task automatic get_resp(input logic [DW-1:0] exp_hdr, input bit is_rd,
                          input logic [DW-1:0] exp_rd, input bit noise);
    int   k = 0;
    int   guard = 0;
    bit   done = 0;
    logic pv = 0, pa = 0, ps = 0, pe = 0;
    logic [DW-1:0] pd = '0;
    while (!done && guard < 1000) begin
      @(negedge clk);
      guard++;
      if (pv && !pa)
        chk(out_data == pd && out_start == ps && out_stop == pe,
            "R8 held beat changed", out_data, pd);
      if (out_valid) begin
        chk(!(out_start && out_stop), "R7 start and stop together",
            {out_start, out_stop}, 0);
        chk(!in_accept, "R11 accept during response", in_accept, 0);
      end
      out_accept = ($urandom % 4) != 0;
      if (noise) begin
        in_valid = 1'($urandom % 2); in_start = 1'b1; in_stop = 1'b1;
        in_data  = mk_hdr(RD, AW'($urandom), HW'($urandom));
      end
      if (out_valid && out_accept) begin
        if (k == 0)
          chk(out_start && !out_stop && out_data == exp_hdr,
              "R5 start beat", out_data, exp_hdr);
        else if (is_rd && k == 1)
          chk(!out_start && !out_stop && out_data == exp_rd,
              "R6 read data beat", out_data, exp_rd);
        else begin
          chk(out_stop && !out_start && out_data == '0,
              "R7 stop beat", out_data, '0);
          done = 1;
        end
        k++;
      end
      pv = out_valid; pa = out_accept; pd = out_data;
      ps = out_start; pe = out_stop;
    end
    chk(k == (is_rd ? 3 : 2), "R6 beat count", DW'(k), DW'(is_rd ? 3 : 2));
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0; out_accept = 1'b0;
    chk(!in_accept && !out_valid, "R10 idle after stop",
        {in_accept, out_valid}, 0);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit noise);
    logic [DW-1:0] h;
    h = mk_hdr(RD, a, HW'($urandom));
    in_beat(h, 1'b1, 1'b1);
    chk(!in_accept, "R3 read header taken", in_accept, 0);
    get_resp(h, 1'b1, model[a], noise);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit junk, input bit noise);
    logic [DW-1:0] h;
    h = mk_hdr(WR, a, HW'($urandom));
    in_beat(h, 1'b1, 1'b0);
    chk(in_accept && !out_valid, "R4 waiting for payload",
        {in_accept, out_valid}, 2);
    if (junk) in_beat(~d, 1'b0, 1'b0);
    in_beat(d, 1'b0, 1'b1);
    model[a] = d;
    get_resp(h, 1'b0, '0, noise);
  endtask

  task automatic drop_beat(input logic [DW-1:0] d, input logic s,
                           input logic e, input string what);
    in_beat(d, s, e);
    for (int i = 0; i < 3; i++) begin
      chk(in_accept && !out_valid, what, {in_accept, out_valid}, 2);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; in_valid = 1'b0; in_start = 1'b0; in_stop = 1'b0;
    in_data = '0; out_accept = 1'b0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(!in_accept && !out_valid, "R1 reset outputs", {in_accept, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_accept && !out_valid, "R2 header wait after reset",
        {in_accept, out_valid}, 2);

    // R1: all registers start at zero
    for (int i = 0; i < NREG; i++) do_read(AW'(i), 1'b0);

    // R4: plain write, and a write with a discarded non-stop payload
    do_write(3'd3, 16'hA55A, 1'b0, 1'b0);
    do_read(3'd3, 1'b0);
    do_write(3'd7, 16'h1234, 1'b1, 1'b0);
    do_read(3'd7, 1'b0);

    // R9: framing and opcode errors are dropped
    drop_beat(mk_hdr(4'h7, 3'd3, '0), 1'b1, 1'b1, "R9 bad opcode dropped");
    drop_beat(mk_hdr(WR, 3'd3, '0), 1'b1, 1'b1, "R9 write with stop dropped");
    drop_beat(mk_hdr(RD, 3'd3, '0), 1'b1, 1'b0, "R9 read without stop dropped");
    drop_beat(mk_hdr(RD, 3'd3, '0), 1'b0, 1'b1, "R9 beat without start ignored");
    drop_beat(mk_hdr(4'h0, 3'd0, '1), 1'b1, 1'b0, "R9 zero opcode dropped");
    do_read(3'd3, 1'b0);

    // R11: headers offered during a response are not taken
    do_write(3'd1, 16'hBEEF, 1'b0, 1'b1);
    do_read(3'd1, 1'b1);

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % NREG);
      if ($urandom % 2) do_write(a, DW'($urandom), 1'($urandom % 2), 1'($urandom % 2));
      else              do_read(a, 1'($urandom % 2));
    end

    // R1: reset in mid-run clears stored values
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!in_accept && !out_valid, "R1 reset outputs mid-run",
        {in_accept, out_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    @(negedge clk);
    chk(in_accept, "R2 header wait after second reset", in_accept, 1);
    do_read(3'd1, 1'b0);
    do_read(3'd7, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule